// File: doc/BRIEF.md
# Four-Lane Vector Execution Stage

This block is the execute stage of a short-vector datapath. Each accepted instruction supplies two 128-bit operands. Each operand is read as four 32-bit elements. The block applies one operation to all four elements in the same cycle, using four identical lanes. The opcode is decoded once per instruction, and the decoded control is fanned out to every lane. The lanes therefore never disagree on which operation they perform.

An active-length input gives the number of lower lanes that hold real elements. Lanes at or above that count do not compute and return zero. The result and its valid flag are registered. They appear one clock after an instruction is accepted. The result is held while no new instruction arrives. Each instruction is computed only from its own operands. No result is forwarded from one instruction into the next.

Top module: `simd4_exec_unit`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `res_valid` is 0 and `res_data` is all zero.
- R2: `res_valid` is 1 exactly in the cycle after a rising clock edge that sampled `instr_valid` high, and 0 otherwise.
- R3: Element i sits in bits [32*i+31:32*i] of `vec_a`, `vec_b` and `res_data`. Element 0 is in the least significant bits. Each lane works only on its own element position.
- R4: Opcode 3'b000 adds the elements. Opcode 3'b001 computes a minus b. Both wrap modulo 2^32 inside each lane, and no carry or borrow crosses into the next lane.
- R5: Opcodes 3'b010, 3'b011 and 3'b100 give the bitwise AND, OR and XOR of the elements.
- R6: Opcode 3'b101 multiplies the elements and keeps the low 32 bits of the product.
- R7: Opcodes 3'b110 and 3'b111 give zero in every lane, with `res_valid` still set.
- R8: With `act_len` equal to k, for k from 1 to 4, lanes 0 to k-1 compute and lanes k to 3 read zero.
- R9: With `act_len` equal to 0, the result is all zero and is still marked valid.
- R10: `act_len` values 5, 6 and 7 behave exactly like 4.
- R11: While `instr_valid` is low, `res_data` keeps its last value.
- R12: Instructions accepted on consecutive cycles each produce the result of their own operands only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction and operands present this cycle |
| opcode | input | 3 | Operation applied to all lanes |
| act_len | input | 3 | Number of active lanes, counted from lane 0 |
| vec_a | input | 128 | First operand, four packed elements |
| vec_b | input | 128 | Second operand, four packed elements |
| res_valid | output | 1 | Result register holds a new result |
| res_data | output | 128 | Registered four-lane result |

## Verification
Each operation is driven with operands that carry a different value in every lane. A lane that reads the wrong element, or a swapped pair of lanes, therefore shows up at once. Add and subtract also get all-ones and zero elements, so that a carry or borrow leaking into the next lane changes an observed element. The active length is swept through 0 to 7 with all lanes nonzero. This separates an off-by-one mask, a missing clamp above four, and a zero length treated as four. Idle cycles between instructions, and back-to-back instructions with different opcodes, tell holding apart from recomputing and from carrying state across instructions.

// File: rtl/simd4_pkg.sv
package simd4_pkg;

    parameter int LANES    = 4;
    parameter int ELEM_W   = 32;
    parameter int VEC_W    = LANES * ELEM_W;
    parameter int OP_W     = 3;
    parameter int LEN_W    = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'b000,
        OP_SUB = 3'b001,
        OP_AND = 3'b010,
        OP_OR  = 3'b011,
        OP_XOR = 3'b100,
        OP_MUL = 3'b101
    } vop_e;

    // one-hot decoded control broadcast to every lane
    typedef struct packed {
        logic add;
        logic sub;
        logic band;
        logic bor;
        logic bxor;
        logic mul;
    } lane_ctrl_t;

    typedef logic [ELEM_W-1:0] elem_t;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] len);
        if (int'(len) > LANES) begin
            return LEN_W'(LANES);
        end
        return len;
    endfunction

endpackage

// File: rtl/simd4_decoder.sv
module simd4_decoder
    import simd4_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output lane_ctrl_t      ctrl
);
    always_comb begin
        ctrl      = '0;
        ctrl.add  = (opcode == OP_ADD);
        ctrl.sub  = (opcode == OP_SUB);
        ctrl.band = (opcode == OP_AND);
        ctrl.bor  = (opcode == OP_OR);
        ctrl.bxor = (opcode == OP_XOR);
        ctrl.mul  = (opcode == OP_MUL);
    end
endmodule

// File: rtl/simd4_len_mask.sv
module simd4_len_mask
    import simd4_pkg::*;
(
    input  logic [LEN_W-1:0] act_len,
    output logic [LANES-1:0] lane_en
);
    logic [LEN_W-1:0] eff_len;

    assign eff_len = clamp_len(act_len);

    for (genvar g = 0; g < LANES; g++) begin : g_en
        assign lane_en[g] = (int'(eff_len) > g);
    end
endmodule

// File: rtl/simd4_lane.sv
module simd4_lane
    import simd4_pkg::*;
(
    input  lane_ctrl_t ctrl,
    input  logic       en,
    input  elem_t      a,
    input  elem_t      b,
    output elem_t      y
);
    elem_t sum, diff, prod;

    assign sum  = a + b;
    assign diff = a - b;
    assign prod = a * b;

    always_comb begin
        y = '0;
        if (en) begin
            unique case (1'b1)
                ctrl.add:  y = sum;
                ctrl.sub:  y = diff;
                ctrl.band: y = a & b;
                ctrl.bor:  y = a | b;
                ctrl.bxor: y = a ^ b;
                ctrl.mul:  y = prod;
                default:   y = '0;
            endcase
        end
    end
endmodule

// File: rtl/simd4_exec_unit.sv
module simd4_exec_unit
    import simd4_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               instr_valid,
    input  logic [OP_W-1:0]    opcode,
    input  logic [LEN_W-1:0]   act_len,
    input  logic [VEC_W-1:0]   vec_a,
    input  logic [VEC_W-1:0]   vec_b,
    output logic               res_valid,
    output logic [VEC_W-1:0]   res_data
);
    lane_ctrl_t        ctrl;
    logic [LANES-1:0]  lane_en;
    logic [VEC_W-1:0]  lane_out;

    simd4_decoder u_dec (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    simd4_len_mask u_mask (
        .act_len (act_len),
        .lane_en (lane_en)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        simd4_lane u_lane (
            .ctrl (ctrl),
            .en   (lane_en[g]),
            .a    (vec_a[g*ELEM_W +: ELEM_W]),
            .b    (vec_b[g*ELEM_W +: ELEM_W]),
            .y    (lane_out[g*ELEM_W +: ELEM_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= instr_valid;
            if (instr_valid) begin
                res_data <= lane_out;
            end
        end
    end
endmodule

// File: rtl/simd4_exec_chk.sv
module simd4_exec_chk
    import simd4_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             instr_valid,
    input logic [OP_W-1:0]  opcode,
    input logic [LEN_W-1:0] act_len,
    input logic             res_valid,
    input logic [VEC_W-1:0] res_data
);
    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        instr_valid |=> res_valid);

    // R2
    valid_drops_chk: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> !res_valid);

    // R11
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> $stable(res_data));

    // R7
    bad_op_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && opcode[2] && opcode[1]) |=> (res_data == '0));

    // R9
    zero_len_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && act_len == '0) |=> (res_data == '0 && res_valid));

    for (genvar g = 1; g < LANES; g++) begin : g_off
        // R8
        lane_off_chk: assert property (@(posedge clk) disable iff (rst)
            (instr_valid && int'(act_len) <= g) |=> (res_data[g*ELEM_W +: ELEM_W] == '0));
    end
endmodule

bind simd4_exec_unit simd4_exec_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .opcode      (opcode),
    .act_len     (act_len),
    .res_valid   (res_valid),
    .res_data    (res_data)
);

// File: tb/tb_simd4_exec_unit.sv
`timescale 1ns/1ps
module tb_simd4_exec_unit;
    logic         clk = 1'b0;
    logic         rst;
    logic         instr_valid;
    logic [2:0]   opcode;
    logic [2:0]   act_len;
    logic [127:0] vec_a;
    logic [127:0] vec_b;
    logic         res_valid;
    logic [127:0] res_data;

    int           n_checks = 0;
    int           n_errors = 0;
    bit           done = 0;

    logic         exp_valid;
    logic [127:0] exp_data;
    string        exp_tag;

    always #2 clk = ~clk;

    simd4_exec_unit dut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .opcode(opcode),
        .act_len(act_len), .vec_a(vec_a), .vec_b(vec_b),
        .res_valid(res_valid), .res_data(res_data)
    );

    function automatic logic [127:0] model(input logic [2:0] op, input logic [2:0] len,
                                           input logic [127:0] a, input logic [127:0] b);
        logic [127:0] r = '0;
        int n = (len > 3'd4) ? 4 : int'(len);
        for (int i = 0; i < n; i++) begin
            logic [31:0] x = a[32*i +: 32];
            logic [31:0] y = b[32*i +: 32];
            logic [63:0] p = 64'(x) * 64'(y);
            logic [31:0] z;
            case (op)
                3'd0: z = 32'((longint'(x) + longint'(y)) % 64'h1_0000_0000);
                3'd1: z = 32'((longint'(x) - longint'(y) + 64'h1_0000_0000) % 64'h1_0000_0000);
                3'd2: z = x & y;
                3'd3: z = x | y;
                3'd4: z = x ^ y;
                3'd5: z = p[31:0];
                default: z = 32'd0;
            endcase
            r[32*i +: 32] = z;
        end
        return r;
    endfunction

    task automatic check_now();
        n_checks++;
        if (res_valid !== exp_valid || res_data !== exp_data) begin
            n_errors++;
            $display("FAIL %s: actual valid=%0b data=%h expected valid=%0b data=%h",
                     exp_tag, res_valid, res_data, exp_valid, exp_data);
        end
    endtask

    // check the outcome of the previous edge, then drive the next instruction
    task automatic cycle(input string tag, input logic v, input logic [2:0] op,
                         input logic [2:0] len, input logic [127:0] a, input logic [127:0] b);
        @(negedge clk);
        check_now();
        instr_valid = v; opcode = op; act_len = len; vec_a = a; vec_b = b;
        exp_tag   = tag;
        exp_valid = v;
        if (v) exp_data = model(op, len, a, b);
    endtask

    localparam logic [127:0] A1 = 128'h89abcdef_01234567_fedcba98_76543210;
    localparam logic [127:0] B1 = 128'h13579bdf_2468ace0_0f0f0f0f_f0f0f0f0;
    localparam logic [127:0] ONES = {4{32'hffff_ffff}};
    localparam logic [127:0] LANE1 = 128'h00000004_00000003_00000002_00000001;

    initial begin
        rst = 1'b1; instr_valid = 0; opcode = 0; act_len = 0; vec_a = '0; vec_b = '0;
        exp_valid = 0; exp_data = '0; exp_tag = "R1 reset";
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_now();
        rst = 1'b0;
        cycle("R1 first cycle after reset", 0, 3'd0, 3'd4, A1, B1);
        cycle("R4 add carry isolation R3", 1, 3'd0, 3'd4, ONES, LANE1);
        cycle("R4 sub borrow isolation R3", 1, 3'd1, 3'd4, LANE1, ONES);
        cycle("R4 add mixed", 1, 3'd0, 3'd4, A1, B1);
        cycle("R4 sub mixed", 1, 3'd1, 3'd4, A1, B1);
        cycle("R5 and", 1, 3'd2, 3'd4, A1, B1);
        cycle("R5 or", 1, 3'd3, 3'd4, A1, B1);
        cycle("R5 xor", 1, 3'd4, 3'd4, A1, B1);
        cycle("R6 mul low half", 1, 3'd5, 3'd4, A1, B1);
        cycle("R6 mul per lane", 1, 3'd5, 3'd4, LANE1, {4{32'h1000_0001}});
        cycle("R2 idle after burst", 0, 3'd0, 3'd4, B1, A1);
        cycle("R11 hold", 0, 3'd5, 3'd4, ONES, ONES);
        cycle("R11 hold again", 0, 3'd1, 3'd0, A1, ONES);
        cycle("R7 opcode 110", 1, 3'd6, 3'd4, A1, B1);
        cycle("R7 opcode 111", 1, 3'd7, 3'd4, A1, B1);
        for (int k = 0; k < 8; k++) begin
            string t = (k == 0) ? "R9 zero length" : (k > 4) ? "R10 length clamp" : "R8 partial length";
            cycle(t, 1, 3'd0, 3'(k), A1, LANE1);
        end
        cycle("R12 back-to-back xor", 1, 3'd4, 3'd3, ONES, A1);
        cycle("R12 back-to-back mul", 1, 3'd5, 3'd2, B1, B1);
        cycle("R12 back-to-back sub", 1, 3'd1, 3'd7, B1, A1);
        for (int i = 0; i < 200; i++) begin
            cycle("R12 mixed stream", 1'($urandom_range(0, 3) != 0), 3'($urandom_range(0, 7)),
                  3'($urandom_range(0, 7)),
                  {$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom});
        end
        cycle("R2 final idle", 0, 3'd0, 3'd0, '0, '0);
        @(negedge clk);
        check_now();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule